// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

An unsigned, purely combinational multiplier. It takes two 8-bit operands and returns their full 16-bit product. The work happens in three phases. First, AND gates form one bit product for every pair of operand bits. Next, a reduction tree squeezes that bit matrix down to two rows; the two rows always sum to the same value as the whole matrix. Last, a parallel-prefix adder sums the two rows.

The tree is built from compressor cells of order N. Each cell has N data bits and N-3 carry-in bits, all at weight 1. It returns a sum bit at weight 1, an output bit at weight 2 and N-3 carry-out bits at weight 2. Carry-outs travel sideways to the same-index carry-ins of the next column up. Carry-out j of a cell never depends on carry-in j of that same cell, so no carry ripples along a row. A parameter picks the order of the first, widest stage: 5, 6 or 7. The tool then inserts as many rows of 4:2 cells as are needed, and a final row of full adders. The result is the same for every choice; only depth and cell mix change.

Top module: `ctm_mul`

## Requirements
- R1: For every pair of operands, `prod_o` equals the exact unsigned product `a_i * b_i`; the 16-bit result never overflows.
- R2: If either operand is zero, the product is zero.
- R3: If one operand is 1, the product equals the other operand, zero-extended.
- R4: 255 times 255 gives 16'hFE01, the largest product.
- R5: `HI_ORDER` can be 5, 6 or 7. Every setting gives identical products for every operand pair.
- R6: Take any compressor of order N. Its N data bits plus its N-3 carry-ins equal its sum bit plus twice the count of its weight-2 output bit and its N-3 carry-outs.
- R7: Multiplying by 2^k (k from 0 to 7) gives the other operand shifted left by k bits.
- R8: Swapping the operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First unsigned operand |
| b_i | input | 8 | Second unsigned operand |
| prod_o | output | 16 | Unsigned product |

## Verification
The bench builds three copies of the multiplier side by side, with `HI_ORDER` set to 7, 6 and 5. Each copy gets every one of the 65,536 operand pairs. With 7, the tree goes straight from the wide stage into the full-adder row. With 6 and 5, a row of 4:2 cells sits in between. With 5, the wide stage leaves five-high columns, so the 4:2 row has to handle pass-through bits. Because the three copies are compared across the whole operand space, each lateral-carry topology is exercised, and so are the padded edge columns.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // column array depth: one spare slot keeps pass-through slices non-empty
  function automatic int col_depth(input int op_w, input int hi);
    return imax(op_w, hi) + 1;
  endfunction

  // rows of 4:2 cells needed after the wide stage before a 3:2 row finishes
  function automatic int mid_stages(input int op_w, input int hi);
    int h;
    int n;
    h = 2 + ((op_w > hi) ? op_w - hi : 0);
    n = 0;
    while (h > 3) begin
      h = 2 + ((h > 4) ? h - 4 : 0);
      n++;
    end
    return n;
  endfunction

  function automatic int stage_order(input int s, input int nstg, input int hi);
    if (s == 0) return hi;
    if (s == nstg - 1) return 3;
    return 4;
  endfunction

endpackage

// File: rtl/ctm_fa.sv
module ctm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/ctm_cmp.sv
// N:2 compressor: ci_i[j] enters adder j+1, co_o[j] leaves adder j
module ctm_cmp #(
  parameter int N = 4
) (
  input  logic [N-1:0] x_i,
  input  logic [N-4:0] ci_i,
  output logic [N-4:0] co_o,
  output logic         s_o,
  output logic         c_o
);
  logic [N-4:0] t;

  ctm_fa u_fa_first (
    .a_i(x_i[0]), .b_i(x_i[1]), .c_i(x_i[2]),
    .s_o(t[0]),   .c_o(co_o[0])
  );

  for (genvar j = 1; j <= N - 4; j++) begin : g_mid
    ctm_fa u_fa (
      .a_i(t[j-1]), .b_i(x_i[j+2]), .c_i(ci_i[j-1]),
      .s_o(t[j]),   .c_o(co_o[j])
    );
  end

  ctm_fa u_fa_last (
    .a_i(t[N-4]), .b_i(x_i[N-1]), .c_i(ci_i[N-4]),
    .s_o(s_o),    .c_o(c_o)
  );
endmodule

// File: rtl/ctm_stage.sv
// One reduction row: order K cell per column, K==3 means plain full adders
module ctm_stage #(
  parameter int COLS = 16,
  parameter int H    = 9,
  parameter int K    = 4
) (
  input  logic [COLS-1:0][H-1:0] col_i,
  output logic [COLS-1:0][H-1:0] col_o
);
  logic [COLS-1:0] sum;
  logic [COLS-1:0] hi;

  if (K == 3) begin : g_fa
    for (genvar c = 0; c < COLS; c++) begin : g_col
      ctm_fa u_fa (
        .a_i(col_i[c][0]), .b_i(col_i[c][1]), .c_i(col_i[c][2]),
        .s_o(sum[c]),      .c_o(hi[c])
      );
    end
  end else begin : g_cmp
    localparam int LW = K - 3;
    logic [LW-1:0] lat [COLS+1];
    logic [LW-1:0] unused_lat;
    assign lat[0] = '0;
    for (genvar c = 0; c < COLS; c++) begin : g_col
      ctm_cmp #(.N(K)) u_cmp (
        .x_i(col_i[c][K-1:0]), .ci_i(lat[c]), .co_o(lat[c+1]),
        .s_o(sum[c]),          .c_o(hi[c])
      );
    end
    // weight beyond the top column is dropped: result is modulo 2^COLS
    assign unused_lat = lat[COLS];
  end

  logic unused_hi;
  assign unused_hi = hi[COLS-1];

  for (genvar c = 0; c < COLS; c++) begin : g_out
    if (c == 0) begin : g_lsb
      assign col_o[c] = {{(K-2){1'b0}}, col_i[c][H-1:K], 1'b0, sum[c]};
    end else begin : g_up
      assign col_o[c] = {{(K-2){1'b0}}, col_i[c][H-1:K], hi[c-1], sum[c]};
    end
  end
endmodule

// File: rtl/ctm_pfx_add.sv
module ctm_pfx_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int L = $clog2(W);

  logic [W-1:0] g [L+1];
  logic [W-1:0] p [L+1];

  assign g[0] = a_i & b_i;
  assign p[0] = a_i ^ b_i;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-D]);
        assign p[l+1][i] = p[l][i] & p[l][i-D];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  assign sum_o[0] = p[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum_o[i] = p[0][i] ^ g[L][i-1];
  end

  logic unused_pg;
  assign unused_pg = ^{p[L], g[L][W-1]};
endmodule

// File: rtl/ctm_mul.sv
module ctm_mul #(
  parameter int OP_W     = 8,
  parameter int HI_ORDER = 7   // 5, 6 or 7
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int COLS = 2 * OP_W;
  localparam int H    = ctm_pkg::col_depth(OP_W, HI_ORDER);
  localparam int NMID = ctm_pkg::mid_stages(OP_W, HI_ORDER);
  localparam int NSTG = NMID + 2;

  logic [COLS-1:0][H-1:0] pp;
  logic [COLS-1:0][H-1:0] st [NSTG+1];

  always_comb begin
    pp = '0;
    for (int i = 0; i < OP_W; i++) begin
      for (int j = 0; j < OP_W; j++) begin
        pp[i+j][(i + j < OP_W) ? j : OP_W - 1 - i] = a_i[i] & b_i[j];
      end
    end
  end

  assign st[0] = pp;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    ctm_stage #(
      .COLS(COLS),
      .H   (H),
      .K   (ctm_pkg::stage_order(s, NSTG, HI_ORDER))
    ) u_stage (
      .col_i(st[s]),
      .col_o(st[s+1])
    );
  end

  logic [COLS-1:0]        row0;
  logic [COLS-1:0]        row1;
  logic [COLS-1:0][H-3:0] unused_rows;

  for (genvar c = 0; c < COLS; c++) begin : g_rows
    assign row0[c]        = st[NSTG][c][0];
    assign row1[c]        = st[NSTG][c][1];
    assign unused_rows[c] = st[NSTG][c][H-1:2];
  end

  ctm_pfx_add #(.W(COLS)) u_add (
    .a_i  (row0),
    .b_i  (row1),
    .sum_o(prod_o)
  );
endmodule

// File: rtl/ctm_chk.sv
module ctm_mul_chk #(
  parameter int OP_W = 8
) (
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic [2*OP_W-1:0] prod_o
);
  logic [2*OP_W-1:0] ref_p;
  assign ref_p = {{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i};

  always_comb begin
    assert_exact_R1: assert (prod_o == ref_p)
      else $error("product %h differs from %h", prod_o, ref_p);
    assert_zero_R2: assert (!((a_i == '0) || (b_i == '0)) || (prod_o == '0))
      else $error("zero operand gave %h", prod_o);
    assert_unit_R3: assert ((b_i != OP_W'(1)) || (prod_o == {{OP_W{1'b0}}, a_i}))
      else $error("unit operand gave %h", prod_o);
    assert_max_R4: assert (!((&a_i) && (&b_i)) || (prod_o[0] && !prod_o[1] && prod_o[2*OP_W-1]))
      else $error("full-scale product %h", prod_o);
  end
endmodule

module ctm_cmp_chk #(
  parameter int N = 4
) (
  input logic [N-1:0] x_i,
  input logic [N-4:0] ci_i,
  input logic [N-4:0] co_o,
  input logic         s_o,
  input logic         c_o
);
  int lhs;
  int rhs;
  assign lhs = $countones(x_i) + $countones(ci_i);
  assign rhs = int'(s_o) + 2 * (int'(c_o) + $countones(co_o));

  always_comb begin
    assert_weight_balance_R6: assert (lhs == rhs)
      else $error("compressor weight %0d vs %0d", lhs, rhs);
  end
endmodule

bind ctm_mul ctm_mul_chk #(.OP_W(OP_W)) u_mul_chk (
  .a_i(a_i), .b_i(b_i), .prod_o(prod_o)
);

bind ctm_cmp ctm_cmp_chk #(.N(N)) u_cmp_chk (
  .x_i(x_i), .ci_i(ci_i), .co_o(co_o), .s_o(s_o), .c_o(c_o)
);

// File: tb/ctm_mul_bench.sv
`timescale 1ns/1ps
module ctm_mul_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_s = '0;
  logic [7:0] b_s = '0;
  logic [15:0] p7, p6, p5;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctm_mul #(.OP_W(8), .HI_ORDER(7)) u_ctm_mul    (.a_i(a_s), .b_i(b_s), .prod_o(p7));
  ctm_mul #(.OP_W(8), .HI_ORDER(6)) u_ctm_mul_h6 (.a_i(a_s), .b_i(b_s), .prod_o(p6));
  ctm_mul #(.OP_W(8), .HI_ORDER(5)) u_ctm_mul_h5 (.a_i(a_s), .b_i(b_s), .prod_o(p5));

  // {a, b, expected product}
  localparam logic [31:0] VEC [8] = '{
    32'h00_00_0000, 32'hFF_FF_FE01, 32'h01_C8_00C8, 32'h80_80_4000,
    32'hFF_01_00FF, 32'h0D_0B_008F, 32'hAA_55_3872, 32'hF0_0F_0E10
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [15:0] exp);
    chk({tag, " h7"}, p7, exp);
    chk({tag, " h6"}, p6, exp);
    chk({tag, " h5"}, p5, exp);
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    a_s = a;
    b_s = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] fwd;
    repeat (3) @(negedge clk);
    chk_all("R2 reset-state zero operands", 16'h0000);
    rst_ni = 1'b1;

    for (int v = 0; v < 8; v++) begin
      drive(VEC[v][31:24], VEC[v][23:16]);
      chk_all("R1 table", VEC[v][15:0]);
    end

    // R2: zero on either side
    drive(8'h00, 8'hE7); chk_all("R2 zero a", 16'h0000);
    drive(8'h9C, 8'h00); chk_all("R2 zero b", 16'h0000);
    // R3: unit on either side
    drive(8'h01, 8'h5B); chk_all("R3 unit a", 16'h005B);
    drive(8'hC4, 8'h01); chk_all("R3 unit b", 16'h00C4);
    // R4: full scale
    drive(8'hFF, 8'hFF); chk_all("R4 full scale", 16'hFE01);
    // R7: powers of two
    for (int k = 0; k < 8; k++) begin
      drive(8'hB7, 8'(1 << k));
      chk_all("R7 shift", 16'(16'h00B7 << k));
    end
    // R8: operand swap
    drive(8'd37, 8'd201);
    fwd = p7;
    drive(8'd201, 8'd37);
    chk_all("R8 swap", fwd);
    chk_all("R8 swap value", 16'd7437);

    // R1 R5 R6: full sweep on every compressor order
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        drive(8'(i), 8'(j));
        chk_all("R1 R5 R6 sweep", 16'(i * j));
      end
    end

    finish_run();
  end
endmodule